// File: doc/BRIEF.md
# Single-Bus Microcoded-Step Processor Core

A compact processor core in which every register transfer travels over one shared internal bus. Each step of an instruction has exactly one register driving the bus. The other registers and the ALU take what they need from it. The core holds four general registers, a program counter, a memory address latch, a memory data latch and an instruction latch. Two hidden registers stage the ALU: an operand register in front of it and a result register behind it. A hardwired step counter produces the transfer strobes for each step.

The core fetches and runs five kinds of instruction: add a memory word to a register, store a register to memory, an unconditional PC-relative jump, a PC-relative jump taken only when an external condition input is high, and halt. Every other kind code acts as a no-op. Memory is reached with one-cycle read or write request pulses. The core then waits for a one-cycle completion pulse, which may arrive any number of cycles later. A step that waits for memory holds the step counter until that pulse arrives.

Instruction word: bits [15:10] are the kind, bits [9:8] select the register, and bits [7:0] hold the address or the signed offset. Kind codes are 0 no-op, 1 add, 2 jump, 3 conditional jump, 4 store and 63 halt.

Top module: `sbusCore`

## Requirements
- R1: Reset clears the PC, all four general registers and the step counter. The first clock after reset is released raises `memRead` with `memAddr` = 0, and a stored general register that was never written reads back as 0.
- R2: Instructions run in address order, and the PC advances by one per fetch. Kind 0 (and any unlisted kind) changes no register other than the PC.
- R3: Add (kind 1) sets register[bits 9:8] to register plus mem[bits 7:0], with 16-bit wraparound. The other registers are unchanged.
- R4: Store (kind 4) writes register[bits 9:8] to mem[bits 7:0] with exactly one write request.
- R5: Jump (kind 2) sets the PC to (address of the jump + 1 + offset), where the offset in bits 7:0 is two's complement, so backward jumps work.
- R6: Conditional jump (kind 3) behaves as R5 when `brCond` is 1. When `brCond` is 0 it finishes in its first execute step and execution continues at the next address.
- R7: Every memory access is one single-cycle request pulse, and the core stalls until `memDone` for any latency of one cycle or more. An add-then-add-then-store-then-halt program issues exactly 6 reads and 1 write.
- R8: At most one register drives the shared bus in any step.
- R9: Halt (kind 63) raises `halted`, keeps it high, and issues no further memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 8 | Memory address (address latch) |
| memWdata | output | 16 | Write data (data latch) |
| memRead | output | 1 | One-cycle read request |
| memWrite | output | 1 | One-cycle write request |
| memRdata | input | 16 | Read data, valid with memDone |
| memDone | input | 1 | One-cycle completion pulse |
| brCond | input | 1 | Condition for the conditional jump |
| halted | output | 1 | High once a halt has executed |

## Verification
The hardest case to reach from the ports is a completion pulse that lands after several stall cycles, while the waiting step keeps reloading the operand register. The bench drives this with a memory model whose latency is set per run from one to five cycles. It checks that only the final arithmetic result and the request counts show up at the ports. Backward jumps are hard to observe directly, so they are exercised by a program that jumps forward, adds, and then jumps back to a store. A wrong sign extension would therefore store the wrong value or never halt.

// File: rtl/sbusPkg.sv
package sbusPkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 8;
  localparam int NREG     = 4;
  localparam int KIND_W   = 6;
  localparam int SEL_W    = $clog2(NREG);
  localparam int OP_W     = KIND_W + SEL_W;
  localparam int FIELD_W  = DATA_W - OP_W;
  localparam int STEP_W   = 3;

  // bus source indices
  localparam int SRC_PC   = 0;
  localparam int SRC_Z    = 1;
  localparam int SRC_MDR  = 2;
  localparam int SRC_IR   = 3;
  localparam int SRC_REG0 = 4;
  localparam int NSRC     = SRC_REG0 + NREG;

  localparam logic [KIND_W-1:0] K_NOP   = 6'd0;
  localparam logic [KIND_W-1:0] K_ADD   = 6'd1;
  localparam logic [KIND_W-1:0] K_BR    = 6'd2;
  localparam logic [KIND_W-1:0] K_BRC   = 6'd3;
  localparam logic [KIND_W-1:0] K_STORE = 6'd4;
  localparam logic [KIND_W-1:0] K_HALT  = 6'd63;

  typedef struct packed {
    logic [NSRC-1:0] outEn;
    logic            pcIn;
    logic            marIn;
    logic            mdrIn;
    logic            irIn;
    logic            yIn;
    logic            zIn;
    logic [NREG-1:0] regIn;
    logic            clearY;
    logic            carryIn;
    logic            read;
    logic            write;
    logic            wmfc;
    logic            endStep;
  } ctlStrobes_t;
endpackage

// File: rtl/sbusDatapath.sv
module sbusDatapath
  import sbusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRead,
  output logic              memWrite,
  output logic [OP_W-1:0]   irOp
);
  logic [DATA_W-1:0] pc, mdr, ir, y, z, bus, aluSum, aluA;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] srcVal [NSRC];
  logic              memBusy, busyRd;

  assign srcVal[SRC_PC]  = pc;
  assign srcVal[SRC_Z]   = z;
  assign srcVal[SRC_MDR] = mdr;
  assign srcVal[SRC_IR]  = {{(DATA_W-FIELD_W){ir[FIELD_W-1]}}, ir[FIELD_W-1:0]};

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign srcVal[SRC_REG0+g] = rf[g];
      always_ff @(posedge clk) begin
        if (!rstN)              rf[g] <= '0;
        else if (strb.regIn[g]) rf[g] <= bus;
      end
    end
  endgenerate

  // shared bus: AND-OR of the enabled source
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      if (strb.outEn[i]) bus = bus | srcVal[i];
  end

  assign aluA   = strb.clearY ? '0 : y;
  assign aluSum = aluA + bus + {{(DATA_W-1){1'b0}}, strb.carryIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0; y <= '0; z <= '0;
      memRead <= 1'b0; memWrite <= 1'b0; memBusy <= 1'b0; busyRd <= 1'b0;
    end else begin
      if (strb.pcIn)  pc  <= bus;
      if (strb.marIn) mar <= bus[ADDR_W-1:0];
      if (strb.irIn)  ir  <= bus;
      if (strb.yIn)   y   <= bus;
      if (strb.zIn)   z   <= aluSum;
      if (memDone && busyRd) mdr <= memRdata;
      else if (strb.mdrIn)   mdr <= bus;
      // requests leave one cycle after the strobe, once MAR/MDR are loaded
      memRead  <= strb.read;
      memWrite <= strb.write;
      if (memRead || memWrite) memBusy <= 1'b1;
      else if (memDone)        memBusy <= 1'b0;
      if (memRead)       busyRd <= 1'b1;
      else if (memWrite) busyRd <= 1'b0;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign irOp     = ir[DATA_W-1:FIELD_W];

  p_one_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.outEn));
  p_done_when_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    memDone |-> memBusy);
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memRead || memWrite) |=> !(memRead || memWrite));
  p_mdr_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memDone && busyRd) |=> (mdr == $past(memRdata)));
endmodule

// File: rtl/sbusControl.sv
module sbusControl
  import sbusPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] irOp,
  input  logic            memDone,
  input  logic            brCond,
  output ctlStrobes_t     strb,
  output logic            halted
);
  localparam logic [STEP_W-1:0] T1 = 3'd1, T2 = 3'd2, T3 = 3'd3, T4 = 3'd4,
                                T5 = 3'd5, T6 = 3'd6, T7 = 3'd7;

  logic [STEP_W-1:0] step;
  logic [KIND_W-1:0] kind;
  logic [SEL_W-1:0]  rsel;
  logic              stall, isJump;

  assign kind   = irOp[OP_W-1:SEL_W];
  assign rsel   = irOp[SEL_W-1:0];
  assign isJump = (kind == K_BR) || (kind == K_BRC);
  assign halted = (step == T4) && (kind == K_HALT);
  assign stall  = strb.wmfc && !memDone;

  always_comb begin
    strb = '0;
    unique case (step)
      T1: begin
        strb.outEn[SRC_PC] = 1'b1; strb.marIn = 1'b1; strb.read = 1'b1;
        strb.clearY = 1'b1; strb.carryIn = 1'b1; strb.zIn = 1'b1;
      end
      T2: begin strb.outEn[SRC_Z] = 1'b1; strb.pcIn = 1'b1; strb.wmfc = 1'b1; end
      T3: begin strb.outEn[SRC_MDR] = 1'b1; strb.irIn = 1'b1; end
      T4: begin
        if (kind == K_ADD) begin
          strb.outEn[SRC_IR] = 1'b1; strb.marIn = 1'b1; strb.read = 1'b1;
        end else if (kind == K_STORE) begin
          strb.outEn[SRC_IR] = 1'b1; strb.marIn = 1'b1;
        end else if (kind == K_BR || (kind == K_BRC && brCond)) begin
          strb.outEn[SRC_PC] = 1'b1; strb.yIn = 1'b1;
        end else if (kind != K_HALT) begin
          strb.endStep = 1'b1;
        end
      end
      T5: begin
        if (kind == K_ADD) begin
          strb.outEn[SRC_REG0+int'(rsel)] = 1'b1; strb.yIn = 1'b1; strb.wmfc = 1'b1;
        end else if (kind == K_STORE) begin
          strb.outEn[SRC_REG0+int'(rsel)] = 1'b1; strb.mdrIn = 1'b1; strb.write = 1'b1;
        end else if (isJump) begin
          strb.outEn[SRC_IR] = 1'b1; strb.zIn = 1'b1;
        end else strb.endStep = 1'b1;
      end
      T6: begin
        if (kind == K_ADD) begin
          strb.outEn[SRC_MDR] = 1'b1; strb.zIn = 1'b1;
        end else if (kind == K_STORE) begin
          strb.wmfc = 1'b1; strb.endStep = 1'b1;
        end else if (isJump) begin
          strb.outEn[SRC_Z] = 1'b1; strb.pcIn = 1'b1; strb.endStep = 1'b1;
        end else strb.endStep = 1'b1;
      end
      T7: begin
        strb.outEn[SRC_Z] = 1'b1; strb.regIn[rsel] = 1'b1; strb.endStep = 1'b1;
      end
      default: strb.endStep = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             step <= T1;
    else if (stall)        step <= step;
    else if (strb.endStep) step <= T1;
    else if (halted)       step <= step;
    else                   step <= step + 3'd1;
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(step));
  p_end_to_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endStep && !stall) |=> (step == T1));
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !(strb.read || strb.write));
endmodule

// File: rtl/sbusCore.sv
module sbusCore
  import sbusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRead,
  output logic              memWrite,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone,
  input  logic              brCond,
  output logic              halted
);
  ctlStrobes_t     strb;
  logic [OP_W-1:0] irOp;

  sbusControl u_ctl (
    .clk(clk), .rstN(rstN), .irOp(irOp), .memDone(memDone),
    .brCond(brCond), .strb(strb), .halted(halted)
  );

  sbusDatapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memDone(memDone),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memRead(memRead), .memWrite(memWrite), .irOp(irOp)
  );
endmodule

// File: tb/sbusCore_tb.sv
`timescale 1ns/1ps
module sbusCore_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = 16'h0;
  logic        memRead, memWrite;
  logic        memDone = 1'b0;
  logic        brCond = 1'b0;
  logic        halted;

  always #2.5 clk = ~clk;

  sbusCore u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRead(memRead), .memWrite(memWrite), .memRdata(memRdata),
    .memDone(memDone), .brCond(brCond), .halted(halted)
  );

  // kind codes and addresses used by the programs
  localparam logic [5:0] NOP = 6'd0, ADD = 6'd1, BR = 6'd2, BRC = 6'd3,
                         STO = 6'd4, HLT = 6'd63;
  localparam logic [7:0] DA = 8'h40, DB = 8'h41, RES = 8'h50;

  // {a, b, latency, register}
  localparam logic [37:0] VEC [6] = '{
    {16'h0003, 16'h0004, 4'd1, 2'd1},
    {16'h1234, 16'h0F0F, 4'd2, 2'd0},
    {16'hFFFF, 16'h0002, 4'd3, 2'd2},
    {16'h8000, 16'h8000, 4'd4, 2'd3},
    {16'h00FF, 16'h0001, 4'd1, 2'd3},
    {16'h7FFF, 16'h0001, 4'd5, 2'd1}
  };

  logic [15:0] mem [256];
  int          lat = 1;
  int          cnt = 0;
  logic [7:0]  pa = 8'h0;
  int          nChk = 0, nBad = 0, nRd = 0, nWr = 0;

  // memory model with programmable completion latency
  always @(posedge clk) begin
    memDone <= 1'b0;
    if (!rstN) cnt <= 0;
    else begin
      if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin memDone <= 1'b1; memRdata <= mem[pa]; end
      end
      if (memRead || memWrite) begin
        if (memWrite) mem[memAddr] <= memWdata;
        pa <= memAddr;
        if (lat <= 1) begin memDone <= 1'b1; memRdata <= mem[memAddr]; end
        else cnt <= lat - 1;
      end
    end
  end

  function automatic logic [15:0] ins(logic [5:0] k, logic [1:0] s, logic [7:0] f);
    return {k, s, f};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem(logic [15:0] a, logic [15:0] b);
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[DA] = a; mem[DB] = b;
    mem[RES] = 16'hDEAD; mem[RES+1] = 16'hDEAD; mem[RES+2] = 16'hDEAD;
  endtask

  task automatic runProg(int latency, logic cond);
    @(negedge clk);
    rstN = 1'b0; lat = latency; brCond = cond; nRd = 0; nWr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 3000 && !halted; c++) begin
      @(negedge clk);
      if (memRead)  nRd++;
      if (memWrite) nWr++;
    end
    if (!halted) begin
      nChk++; nBad++;
      $display("FAIL watchdog: program did not halt, actual=running expected=halted");
    end
  endtask

  initial begin
    logic [15:0] a, b, sum;
    logic [1:0]  s;
    int          q;

    // R1: reset state and first request
    clearMem(16'h0, 16'h0);
    repeat (3) @(negedge clk);
    check("R1 request idle in reset", {15'b0, memRead}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first read after reset", {15'b0, memRead}, 16'h1);
    check("R1 first address", {8'h0, memAddr}, 16'h0);

    // table walk: add, add, store, halt (R3 R4 R7 R8)
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][37:22]; b = VEC[v][21:6]; s = VEC[v][1:0];
      sum = a + b;
      clearMem(a, b);
      mem[0] = ins(ADD, s, DA);
      mem[1] = ins(ADD, s, DB);
      mem[2] = ins(STO, s, RES);
      mem[3] = ins(HLT, 2'd0, 8'h0);
      runProg(int'(VEC[v][5:2]), 1'b0);
      check($sformatf("R3 R4 R8 vector %0d sum", v), mem[RES], sum);
      if (v == 0) begin
        check("R7 read request count", 16'(nRd), 16'd6);
        check("R7 write request count", 16'(nWr), 16'd1);
      end
    end

    a = 16'h0005; b = 16'h0030;

    // R2: no-op advances without touching registers
    clearMem(a, b);
    mem[0] = ins(NOP, 2'd1, 8'h77);
    mem[1] = ins(ADD, 2'd1, DA);
    mem[2] = ins(STO, 2'd1, RES);
    mem[3] = ins(HLT, 2'd0, 8'h0);
    runProg(2, 1'b0);
    check("R2 no-op then add", mem[RES], a);

    // R1 R3: registers independent, untouched register reads zero
    clearMem(a, b);
    mem[0] = ins(ADD, 2'd2, DA);
    mem[1] = ins(ADD, 2'd3, DB);
    mem[2] = ins(STO, 2'd2, RES);
    mem[3] = ins(STO, 2'd3, RES + 8'd1);
    mem[4] = ins(STO, 2'd0, RES + 8'd2);
    mem[5] = ins(HLT, 2'd0, 8'h0);
    runProg(1, 1'b0);
    check("R3 register two", mem[RES], a);
    check("R3 register three", mem[RES+1], b);
    check("R1 register zero cleared", mem[RES+2], 16'h0);

    // R5: forward jump skips one add
    clearMem(a, b);
    mem[0] = ins(BR, 2'd0, 8'h01);
    mem[1] = ins(ADD, 2'd1, DA);
    mem[2] = ins(ADD, 2'd1, DB);
    mem[3] = ins(STO, 2'd1, RES);
    mem[4] = ins(HLT, 2'd0, 8'h0);
    runProg(2, 1'b0);
    check("R5 forward jump", mem[RES], b);

    // R5: backward jump with negative offset
    clearMem(a, b);
    mem[0] = ins(BR, 2'd0, 8'h02);
    mem[1] = ins(STO, 2'd1, RES);
    mem[2] = ins(HLT, 2'd0, 8'h0);
    mem[3] = ins(ADD, 2'd1, DA);
    mem[4] = ins(BR, 2'd0, 8'hFC);
    runProg(3, 1'b0);
    check("R5 backward jump", mem[RES], a);

    // R6: conditional jump taken and not taken
    for (int t = 0; t < 2; t++) begin
      clearMem(a, b);
      mem[0] = ins(BRC, 2'd0, 8'h01);
      mem[1] = ins(ADD, 2'd1, DA);
      mem[2] = ins(ADD, 2'd1, DB);
      mem[3] = ins(STO, 2'd1, RES);
      mem[4] = ins(HLT, 2'd0, 8'h0);
      runProg(1, t[0]);
      check(t == 1 ? "R6 condition true" : "R6 condition false",
            mem[RES], (t == 1) ? b : 16'(a + b));
    end

    // R9: halt stays quiet
    q = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (memRead || memWrite) q++;
    end
    check("R9 requests after halt", 16'(q), 16'd0);
    check("R9 halted held", {15'b0, halted}, 16'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule